// File: doc/BRIEF.md
# Two-Bank Multiplexed-Address DRAM Controller with Refresh

This block connects a 16-bit processor bus to two banks of DRAM whose address pins are shared between row and column. It takes a 20-bit byte address. It splits the word address into a row half and a column half and drives them one after the other on a 9-bit address bus. An active-low row strobe latches the row half, then an active-low column strobe latches the column half. The top address bit chooses the bank, and only that bank's strobe pair moves. On writes the block also drives two active-low byte-lane enables.

A free-running timer raises a refresh request every `REF_PERIOD` clocks. The request is served the next time the sequencer is idle, as a RAS-only cycle. In that cycle both row strobes fall together, no column strobe moves, and the address bus carries an internal refresh row counter. A processor access that arrives while a refresh is in progress waits, with `ready` held low. Every row-strobe low period is followed by at least one clock of precharge.

Top module: `dramc_top`

## Requirements
- R1: During the row phase the address bus carries byte-address bits 18..10. During the column phase it carries bits 9..1.
- R2: An access takes exactly two strobe cycles. In the first, the selected row strobe is low and both column strobes are high. In the next, the same row strobe and its column strobe are both low.
- R3: Address bit 19 selects the bank: 0 strobes `ras0_n`/`cas0_n` and 1 strobes `ras1_n`/`cas1_n`. The other pair stays high for the whole access, and the two column strobes are never low together.
- R4: On a write, `wel_n` is low in the column cycle when address bit 0 is 0, and `weh_n` is low in the column cycle when `cpu_bhe_n` is 0. A write with bit 0 = 1 and `cpu_bhe_n` = 1 enables neither lane.
- R5: On a read, both lane enables stay high. For every access, `ready` is high for exactly the column cycle.
- R6: A refresh drives both row strobes low together for `REF_CYC` clocks, keeps both column strobes high, and puts the refresh row on the address bus.
- R7: The refresh row is 0 after reset and advances by one after each refresh. It wraps from 511 to 0.
- R8: With no accesses, a refresh starts every `REF_PERIOD` clocks.
- R9: A pending refresh is served before a waiting access. An access raised during a refresh gets `ready` five clocks later: two refresh or precharge cycles, then idle, row and column. Continuous requests do not prevent refresh.
- R10: After any row-strobe low period, both row strobes are high for at least one clock.
- R11: After reset, all four strobes and both lane enables are high and `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_addr | input | 20 | Processor byte address. Bit 19 selects the bank, bits 18..1 are the word address, bit 0 selects the low byte |
| cpu_bhe_n | input | 1 | Active-low high-byte enable |
| rd_req | input | 1 | Read request, held until `ready` |
| wr_req | input | 1 | Write request, held until `ready` |
| dram_ma | output | 9 | Multiplexed DRAM address bus |
| ras0_n | output | 1 | Row strobe, bank 0 |
| cas0_n | output | 1 | Column strobe, bank 0 |
| ras1_n | output | 1 | Row strobe, bank 1 |
| cas1_n | output | 1 | Column strobe, bank 1 |
| wel_n | output | 1 | Low-byte write enable |
| weh_n | output | 1 | High-byte write enable |
| ready | output | 1 | Access completes in this cycle |

## Verification
The hardest situation to reach from the ports is a processor request that lands while a refresh is already running. From outside, the timer phase can only be seen as strobe activity. The stimulus therefore waits for the first cycle in which both row strobes are low, raises a read in that same cycle, and measures the delay to `ready`. A stream of back-to-back reads then shows that refresh still wins the idle slots. A long idle stretch lets the refresh row counter pass its wrap point while every refresh address is compared against a running count.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  // Sequencer states: one access is IDLE -> ROW -> COL -> PRE,
  // one refresh is IDLE -> REF (REF_CYC clocks) -> PRE.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_PRE  = 3'd3,
    ST_REF  = 3'd4
  } dram_state_t;

  // Source selection for the shared DRAM address bus.
  typedef enum logic [1:0] {
    MA_ROW = 2'd0,
    MA_COL = 2'd1,
    MA_REF = 2'd2
  } ma_sel_t;

endpackage

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer #(
  parameter int REF_PERIOD = 3120,
  parameter int ROW_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ack,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);

  localparam int              CNT_W    = $clog2(REF_PERIOD);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;
  logic             pend_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    tick   = (cnt_q == CNT_LAST);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    // a new period end wins over the acknowledge of the previous one
    pend_d = tick | (ref_pend & ~ref_ack);
    row_d  = ref_row + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      cnt_q    <= cnt_d;
      ref_pend <= pend_d;
      if (ref_done) begin
        ref_row <= row_d;
      end
    end
  end

  // R7
  row_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> (ref_row == $past(ref_row) + 1'b1));

  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_done |=> $stable(ref_row));

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && !ref_ack) |=> ref_pend);

endmodule

// File: rtl/dramc_addr_path.sv
module dramc_addr_path
  import dramc_pkg::*;
#(
  parameter int ROW_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic [2*ROW_W+1:0] addr_i,
  input  logic               bhe_n_i,
  input  logic               wr_i,
  input  ma_sel_t            ma_sel,
  input  logic [ROW_W-1:0]   ref_row,
  output logic [ROW_W-1:0]   ma,
  output logic               bank_o,
  output logic               lane_lo_o,
  output logic               lane_hi_o,
  output logic               wr_o
);

  localparam int COL_LSB  = 1;
  localparam int ROW_LSB  = COL_LSB + ROW_W;
  localparam int BANK_BIT = ROW_LSB + ROW_W;

  logic [ROW_W-1:0] row_q, col_q;

  // Capture the whole request once, on entry to the row phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q     <= '0;
      col_q     <= '0;
      bank_o    <= 1'b0;
      lane_lo_o <= 1'b0;
      lane_hi_o <= 1'b0;
      wr_o      <= 1'b0;
    end else if (cap_en) begin
      row_q     <= addr_i[ROW_LSB +: ROW_W];
      col_q     <= addr_i[COL_LSB +: ROW_W];
      bank_o    <= addr_i[BANK_BIT];
      lane_lo_o <= ~addr_i[0];
      lane_hi_o <= ~bhe_n_i;
      wr_o      <= wr_i;
    end
  end

  always_comb begin
    unique case (ma_sel)
      MA_COL:  ma = col_q;
      MA_REF:  ma = ref_row;
      default: ma = row_q;
    endcase
  end

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int REF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_req,
  input  logic       wr_req,
  input  logic       ref_pend,
  input  logic       bank_i,
  input  logic       wr_i,
  input  logic       lane_lo_i,
  input  logic       lane_hi_i,
  output logic       cap_en,
  output logic       ref_ack,
  output logic       ref_done,
  output ma_sel_t    ma_sel,
  output logic [1:0] ras_n,
  output logic [1:0] cas_n,
  output logic       wel_n,
  output logic       weh_n,
  output logic       ready
);

  localparam int NBANK = 2;
  localparam int RC_W  = $clog2(REF_CYC + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(REF_CYC - 1);

  dram_state_t      state_q, state_d;
  logic [RC_W-1:0]  rc_q, rc_d;
  logic             req_any;
  logic             rc_last;

  assign req_any = rd_req | wr_req;
  assign rc_last = (rc_q == RC_LAST);

  always_comb begin
    state_d  = state_q;
    rc_d     = '0;
    cap_en   = 1'b0;
    ref_ack  = 1'b0;
    ref_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          ref_ack = 1'b1;
          state_d = ST_REF;
        end else if (req_any) begin
          cap_en  = 1'b1;
          state_d = ST_ROW;
        end
      end
      ST_ROW:  state_d = ST_COL;
      ST_COL:  state_d = ST_PRE;
      ST_PRE:  state_d = ST_IDLE;
      ST_REF: begin
        if (rc_last) begin
          ref_done = 1'b1;
          state_d  = ST_PRE;
        end else begin
          rc_d = rc_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rc_q    <= '0;
    end else begin
      state_q <= state_d;
      rc_q    <= rc_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_COL:  ma_sel = MA_COL;
      ST_REF:  ma_sel = MA_REF;
      default: ma_sel = MA_ROW;
    endcase
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit      = (bank_i == 1'(b));
    assign ras_n[b] = ~((hit && (state_q == ST_ROW || state_q == ST_COL))
                        || (state_q == ST_REF));
    assign cas_n[b] = ~(hit && (state_q == ST_COL));

    // R2
    ras_to_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n[b]) && ras_n[1-b]) |=> (!cas_n[b] && !ras_n[b]));

    // R10
    precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n[b]) |=> ras_n[b]);
  end

  assign ready = (state_q == ST_COL);
  assign wel_n = ~((state_q == ST_COL) && wr_i && lane_lo_i);
  assign weh_n = ~((state_q == ST_COL) && wr_i && lane_hi_i);

  // R3
  cas_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cas_n) <= 1);

  // R6
  ref_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&(~ras_n)) |-> (&cas_n));

  // R5
  ready_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !(&cas_n));

  // R4
  lane_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel_n || !weh_n) |-> (ready && !(&cas_n)));

  // R9
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && ref_pend) |=> (state_q == ST_REF));

endmodule

// File: rtl/dramc_top.sv
module dramc_top
  import dramc_pkg::*;
#(
  parameter int ROW_W      = 9,
  parameter int REF_PERIOD = 3120,
  parameter int REF_CYC    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*ROW_W+1:0] cpu_addr,
  input  logic               cpu_bhe_n,
  input  logic               rd_req,
  input  logic               wr_req,
  output logic [ROW_W-1:0]   dram_ma,
  output logic               ras0_n,
  output logic               cas0_n,
  output logic               ras1_n,
  output logic               cas1_n,
  output logic               wel_n,
  output logic               weh_n,
  output logic               ready
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             cap_en, ref_ack, ref_done, ref_pend;
  logic             bank, lane_lo, lane_hi, wr_cap;
  logic [ROW_W-1:0] ref_row;
  logic [1:0]       ras_n, cas_n;
  ma_sel_t          ma_sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  dramc_ref_timer #(
    .REF_PERIOD (REF_PERIOD),
    .ROW_W      (ROW_W)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ref_ack  (ref_ack),
    .ref_done (ref_done),
    .ref_pend (ref_pend),
    .ref_row  (ref_row)
  );

  dramc_addr_path #(
    .ROW_W (ROW_W)
  ) i_addr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cap_en    (cap_en),
    .addr_i    (cpu_addr),
    .bhe_n_i   (cpu_bhe_n),
    .wr_i      (wr_req),
    .ma_sel    (ma_sel),
    .ref_row   (ref_row),
    .ma        (dram_ma),
    .bank_o    (bank),
    .lane_lo_o (lane_lo),
    .lane_hi_o (lane_hi),
    .wr_o      (wr_cap)
  );

  dramc_seq #(
    .REF_CYC (REF_CYC)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .ref_pend  (ref_pend),
    .bank_i    (bank),
    .wr_i      (wr_cap),
    .lane_lo_i (lane_lo),
    .lane_hi_i (lane_hi),
    .cap_en    (cap_en),
    .ref_ack   (ref_ack),
    .ref_done  (ref_done),
    .ma_sel    (ma_sel),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .wel_n     (wel_n),
    .weh_n     (weh_n),
    .ready     (ready)
  );

  assign ras0_n = ras_n[0];
  assign ras1_n = ras_n[1];
  assign cas0_n = cas_n[0];
  assign cas1_n = cas_n[1];

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (ras0_n && ras1_n && cas0_n && cas1_n && !ready));

endmodule

// File: tb/test_dramc_top.sv
`timescale 1ns/1ps
module test_dramc_top;

  localparam int ROW_W      = 9;
  localparam int REF_PERIOD = 64;
  localparam int REF_CYC    = 2;

  // {addr[19:0], bhe_n, wr, expected wel_n, expected weh_n}
  localparam logic [23:0] VEC [8] = '{
    {20'h00002, 1'b0, 1'b1, 1'b0, 1'b0},
    {20'h84C06, 1'b1, 1'b1, 1'b0, 1'b1},
    {20'h3FFFF, 1'b0, 1'b1, 1'b1, 1'b0},
    {20'hFFFFF, 1'b1, 1'b1, 1'b1, 1'b1},
    {20'h01234, 1'b0, 1'b0, 1'b1, 1'b1},
    {20'h80000, 1'b1, 1'b0, 1'b1, 1'b1},
    {20'h55554, 1'b0, 1'b1, 1'b0, 1'b0},
    {20'hAAAAA, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [19:0]      cpu_addr = '0;
  logic             cpu_bhe_n = 1'b1;
  logic             rd_req = 1'b0;
  logic             wr_req = 1'b0;
  logic [ROW_W-1:0] dram_ma;
  logic             ras0_n, cas0_n, ras1_n, cas1_n, wel_n, weh_n, ready;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  int ref_count = 0;
  logic iv_on = 1'b0;

  always #2.5 clk = ~clk;

  dramc_top #(
    .ROW_W      (ROW_W),
    .REF_PERIOD (REF_PERIOD),
    .REF_CYC    (REF_CYC)
  ) i_dramc_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_bhe_n (cpu_bhe_n),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .dram_ma   (dram_ma),
    .ras0_n    (ras0_n),
    .cas0_n    (cas0_n),
    .ras1_n    (ras1_n),
    .cas1_n    (cas1_n),
    .wel_n     (wel_n),
    .weh_n     (weh_n),
    .ready     (ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- refresh monitor ----------------
  logic [ROW_W-1:0] exp_row;
  logic ref_prev, iv_prev, have_last;
  int   cyc, last_start;

  task automatic mchk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
    mon_checks++;
    if (!ok) begin
      mon_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_row   = '0;
      ref_prev  = 1'b0;
      iv_prev   = 1'b0;
      have_last = 1'b0;
      cyc       = 0;
      last_start = 0;
    end else begin
      logic ref_now;
      cyc++;
      ref_now = !ras0_n && !ras1_n;
      if (iv_on && !iv_prev) have_last = 1'b0;
      iv_prev = iv_on;
      if (ref_now) begin
        // R6: RAS-only, no CAS; R9: no ready during refresh
        mchk(cas0_n && cas1_n, "R6", "cas during refresh", {cas1_n, cas0_n}, 2'b11);
        mchk(!ready, "R9", "ready during refresh", ready, 0);
      end
      if (ref_now && !ref_prev) begin
        mchk(dram_ma == exp_row, "R7", "refresh row", dram_ma, exp_row);
        if (iv_on && have_last)
          mchk(cyc - last_start == REF_PERIOD, "R8", "refresh interval",
               cyc - last_start, REF_PERIOD);
        have_last  = iv_on;
        last_start = cyc;
        ref_count++;
      end
      if (!ref_now && ref_prev) begin
        mchk(ras0_n && ras1_n, "R10", "precharge after refresh",
             {ras1_n, ras0_n}, 2'b11);
        exp_row = exp_row + 1'b1;
      end
      ref_prev = ref_now;
    end
  end

  // ---------------- access task ----------------
  task automatic do_access(input logic [19:0] a, input logic b, input logic w,
                           input logic xlo, input logic xhi, output int lat);
    logic [ROW_W-1:0] p_ma;
    logic p_r0, p_r1, p_c0, p_c1;
    logic bk;
    logic [ROW_W-1:0] row, col;
    bit done;
    bk  = a[19];
    row = a[18:10];
    col = a[9:1];
    cpu_addr = a; cpu_bhe_n = b; wr_req = w; rd_req = !w;
    lat = 0; done = 0;
    p_ma = '0; p_r0 = 1'b1; p_r1 = 1'b1; p_c0 = 1'b1; p_c1 = 1'b1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
      if (ready) begin
        done = 1;
        // R1 / R2 / R3 row phase
        chk(p_ma == row, "R1", "row address", p_ma, row);
        chk((bk ? (!p_r1 && p_r0) : (!p_r0 && p_r1)) && p_c0 && p_c1, "R2",
            "row phase strobes", {p_r1, p_r0, p_c1, p_c0},
            bk ? 4'b0111 : 4'b1011);
        // column phase
        chk(dram_ma == col, "R1", "column address", dram_ma, col);
        chk(bk ? ({ras1_n, cas1_n, ras0_n, cas0_n} == 4'b0011)
               : ({ras1_n, cas1_n, ras0_n, cas0_n} == 4'b1100), "R3",
            "column phase strobes", {ras1_n, cas1_n, ras0_n, cas0_n},
            bk ? 4'b0011 : 4'b1100);
        chk({wel_n, weh_n} == {xlo, xhi}, w ? "R4" : "R5", "lane enables",
            {wel_n, weh_n}, {xlo, xhi});
        wr_req = 1'b0; rd_req = 1'b0;
      end else begin
        p_ma = dram_ma; p_r0 = ras0_n; p_r1 = ras1_n; p_c0 = cas0_n; p_c1 = cas1_n;
      end
    end
    if (!done) begin
      chk(1'b0, "R5", "ready timeout", 0, 1);
      wr_req = 1'b0; rd_req = 1'b0;
    end
    @(negedge clk);
    chk(ras0_n && ras1_n && !ready, "R10", "precharge after access",
        {ready, ras1_n, ras0_n}, 3'b011);
    chk({wel_n, weh_n} == 2'b11, "R4", "lanes released", {wel_n, weh_n}, 2'b11);
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int lat;
    int r0, rd_cnt;
    repeat (4) @(negedge clk);
    // R11 during reset
    chk({ras0_n, cas0_n, ras1_n, cas1_n, wel_n, weh_n, ready} == 7'b1111110,
        "R11", "reset outputs", {ras0_n, cas0_n, ras1_n, cas1_n, wel_n, weh_n, ready},
        7'b1111110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({ras0_n, cas0_n, ras1_n, cas1_n, wel_n, weh_n, ready} == 7'b1111110,
        "R11", "after reset", {ras0_n, cas0_n, ras1_n, cas1_n, wel_n, weh_n, ready},
        7'b1111110);

    // table of accesses
    for (int i = 0; i < 8; i++) begin
      logic [23:0] v;
      v = VEC[i];
      do_access(v[23:4], v[3], v[2], v[1], v[0], lat);
    end

    // R9: request raised in the first cycle of a refresh
    do @(negedge clk); while (!(!ras0_n && !ras1_n));
    do_access(20'h0F0F0, 1'b0, 1'b0, 1'b1, 1'b1, lat);
    chk(lat == 5, "R9", "access latency behind refresh", lat, 5);

    // R9: continuous reads still let refresh in
    r0 = ref_count; rd_cnt = 0;
    cpu_addr = 20'h81111; cpu_bhe_n = 1'b0; rd_req = 1'b1;
    repeat (400) begin
      @(negedge clk);
      if (ready) rd_cnt++;
    end
    rd_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(ref_count - r0 >= 5, "R9", "refreshes under load", ref_count - r0, 5);
    chk(rd_cnt >= 80, "R5", "reads under load", rd_cnt, 80);

    // R8 / R7: long idle stretch, row counter passes its wrap point
    iv_on = 1'b1;
    r0 = ref_count;
    repeat (520 * REF_PERIOD) @(negedge clk);
    iv_on = 1'b0;
    chk(ref_count - r0 >= 515, "R7", "refreshes through wrap", ref_count - r0, 515);
    chk(ref_count >= 512, "R7", "total refresh count past wrap", ref_count, 512);

    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks, errors + mon_errors);
    $finish;
  end

endmodule